// File: doc/BRIEF.md
# Video Horizontal Slot Timing Generator

This block produces the horizontal timing of one scanline for a tile-based video display processor. An 8-bit slot counter steps once for each accepted slot enable. It runs from 0x00 upward and then jumps over a band of values that depends on the mode, before it runs on to 0xFF and wraps. The jump gives a scanline length that is not a power of two. From the counter the block derives the line phases: active display, right border, front porch, sync, back porch and left border. It also fires a horizontal interrupt strobe and, on the first vertical-blank line, a vertical interrupt strobe.

Two horizontal modes exist. The narrow mode has 32 cells and a 171-slot line. The wide mode has 40 cells and a 210-slot line. In the wide mode every slot inside the sync segment is stretched so that it takes two slot enables. The mode input is sampled only at reset and when the counter wraps to 0x00, so a line never changes shape halfway through.

A phase state machine follows the counter. Its states are ACTIVE, RBORDER, FPORCH, SYNC, BPORCH and LBORDER. Each transition is taken on a counter step whose next slot value equals the boundary of the current mode:
- ACTIVE to RBORDER at the right-border start.
- RBORDER to FPORCH at the blanking start.
- FPORCH to SYNC at the sync start.
- SYNC to BPORCH at the back-porch start.
- BPORCH to LBORDER at 0xFB.
- LBORDER to ACTIVE at 0x00.

Top module: `hslot_timing_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the block loads `slot`=0x00, sets `active`=1 and drives all other flags and both strobes to 0. At the same edge it samples `wide_mode` as the line's mode.
- R2: `slot` changes only on a clock edge where `slot_en` is 1. When `slot_en` is 0, every output except the strobes holds its value.
- R3: In narrow mode the counter steps 0x00..0x93, then goes to 0xE9, then runs 0xE9..0xFF and wraps to 0x00. This gives 171 slots per line.
- R4: In wide mode the counter steps 0x00..0xB6, then goes to 0xE5, then runs 0xE5..0xFF and wraps to 0x00. This gives 210 slots per line.
- R5: In wide mode each slot for which `hsync` is 1 lasts two slot enables: the first enable is absorbed and the second one advances the counter. Narrow-mode slots always last one enable.
- R6: A change on `wide_mode` takes effect only on the step that wraps the counter to 0x00.
- R7: `active` is 1 for slots 0x00..0x7F in narrow mode and for slots 0x00..0x9F in wide mode.
- R8: `right_border` is 1 for slots 0x80..0x87 in narrow mode and for slots 0xA0..0xA7 in wide mode.
- R9: `hblank` is 1 from 0x88 to 0xFA in narrow mode (30 slots, across the gap) and from 0xA8 to 0xFA in wide mode (37 slots). In slots 0xFB..0xFF all flags are 0.
- R10: `hsync` is 1 for slots 0x8C..0xED in narrow mode (13 slots) and for slots 0xAD..0xEA in wide mode (16 slots). Before sync, blanking has a 4-slot front porch in narrow mode and a 5-slot front porch in wide mode.
- R11: `hint_stb` is high for exactly the one clock in which `slot` first shows 0x85 in narrow mode or 0xA5 in wide mode.
- R12: `vint_stb` is high for exactly the one clock in which `slot` first shows 0x01, provided `first_vblank` was 1 on the step that entered 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slot_en | input | 1 | Slot enable tick |
| wide_mode | input | 1 | 1 selects the 40-cell mode, 0 selects the 32-cell mode |
| first_vblank | input | 1 | Current line is the first vertical-blank line |
| slot | output | 8 | Current slot count |
| active | output | 1 | Active display phase |
| right_border | output | 1 | Right border phase |
| hblank | output | 1 | Horizontal blanking |
| hsync | output | 1 | Horizontal sync |
| hint_stb | output | 1 | Horizontal interrupt strobe |
| vint_stb | output | 1 | Vertical interrupt strobe |

## Verification
The bench runs full lines in each mode with a slot enable on every clock. These runs separate the two gap jumps, the phase boundaries and the strobe slots. It then thins the enable to a sparse pattern, which shows whether the counter, the phase machine and the strobes hold while the enable is low. In wide mode the same sparse pattern also exposes the two-enable sync slots. The mode input is toggled in the middle of a line, which tells a design that latches the mode at the wrap apart from one that follows the input at once. The vertical-blank input is held high across whole lines and also pulsed away from slot 0x01, so a strobe that ignores either the slot or the input is caught. A reset in the middle of a line then shows that the counter returns to 0x00 and that the mode is sampled again.

// File: rtl/hst_pkg.sv
package hst_pkg;

    localparam int SLOT_W = 8;

    typedef logic [SLOT_W-1:0] slot_t;

    typedef enum logic [2:0] {
        PH_ACTIVE,
        PH_RBORDER,
        PH_FPORCH,
        PH_SYNC,
        PH_BPORCH,
        PH_LBORDER
    } phase_e;

    typedef struct packed {
        slot_t gap_from;   // last slot before the jump
        slot_t gap_to;     // slot loaded after the jump
        slot_t rb_start;
        slot_t hb_start;
        slot_t hs_start;
        slot_t bp_start;
        slot_t hint_at;
    } profile_t;

    localparam slot_t LB_START = 8'hFB;
    localparam slot_t VINT_AT  = 8'h01;

    function automatic profile_t mode_profile(input logic wide);
        profile_t p;
        if (wide) begin
            p.gap_from = 8'hB6;
            p.gap_to   = 8'hE5;
            p.rb_start = 8'hA0;
            p.hb_start = 8'hA8;
            p.hs_start = 8'hAD;
            p.bp_start = 8'hEB;
            p.hint_at  = 8'hA5;
        end else begin
            p.gap_from = 8'h93;
            p.gap_to   = 8'hE9;
            p.rb_start = 8'h80;
            p.hb_start = 8'h88;
            p.hs_start = 8'h8C;
            p.bp_start = 8'hEE;
            p.hint_at  = 8'h85;
        end
        return p;
    endfunction

endpackage

// File: rtl/hst_slot_counter.sv
module hst_slot_counter
    import hst_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  slot_en,
    input  logic  wide_mode,
    input  logic  in_sync,
    output slot_t slot_q,
    output slot_t slot_nxt,
    output logic  step,
    output logic  wide_q
);

    profile_t prof;
    logic     half_q;
    logic     absorb;

    always_comb begin
        prof     = mode_profile(wide_q);
        absorb   = wide_q && in_sync && !half_q;
        step     = slot_en && !absorb;
        slot_nxt = (slot_q == prof.gap_from) ? prof.gap_to : slot_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
            half_q <= 1'b0;
            wide_q <= wide_mode;
        end else if (slot_en) begin
            if (absorb) begin
                half_q <= 1'b1;
            end else begin
                half_q <= 1'b0;
                slot_q <= slot_nxt;
                if (slot_nxt == '0) begin
                    wide_q <= wide_mode;
                end
            end
        end
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !slot_en |=> $stable(slot_q));

    p_gap_narrow_r3: assert property (@(posedge clk) disable iff (rst)
        (step && !wide_q && slot_q == 8'h93) |=> (slot_q == 8'hE9));

    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (step && slot_q == 8'hFF) |=> (slot_q == 8'h00));

    p_gap_wide_r4: assert property (@(posedge clk) disable iff (rst)
        (step && wide_q && slot_q == 8'hB6) |=> (slot_q == 8'hE5));

    p_stretch_r5: assert property (@(posedge clk) disable iff (rst)
        (slot_en && wide_q && in_sync && !half_q) |=> $stable(slot_q));

    p_mode_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        !(step && slot_nxt == '0) |=> $stable(wide_q));

endmodule

// File: rtl/hst_phase_fsm.sv
module hst_phase_fsm
    import hst_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  step,
    input  slot_t slot_nxt,
    input  logic  wide_q,
    output logic  active,
    output logic  right_border,
    output logic  hblank,
    output logic  hsync
);

    phase_e   state_q;
    phase_e   state_d;
    profile_t prof;

    always_comb begin
        prof    = mode_profile(wide_q);
        state_d = state_q;
        if (step) begin
            unique case (state_q)
                PH_ACTIVE:  if (slot_nxt == prof.rb_start) state_d = PH_RBORDER;
                PH_RBORDER: if (slot_nxt == prof.hb_start) state_d = PH_FPORCH;
                PH_FPORCH:  if (slot_nxt == prof.hs_start) state_d = PH_SYNC;
                PH_SYNC:    if (slot_nxt == prof.bp_start) state_d = PH_BPORCH;
                PH_BPORCH:  if (slot_nxt == LB_START)      state_d = PH_LBORDER;
                PH_LBORDER: if (slot_nxt == '0)            state_d = PH_ACTIVE;
                default:                                   state_d = PH_ACTIVE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_ACTIVE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        active       = 1'b0;
        right_border = 1'b0;
        hblank       = 1'b0;
        hsync        = 1'b0;
        unique case (state_q)
            PH_ACTIVE:  active       = 1'b1;
            PH_RBORDER: right_border = 1'b1;
            PH_FPORCH:  hblank       = 1'b1;
            PH_SYNC: begin
                hblank = 1'b1;
                hsync  = 1'b1;
            end
            PH_BPORCH:  hblank       = 1'b1;
            PH_LBORDER: ;
            default:    ;
        endcase
    end

    p_sync_in_blank_r10: assert property (@(posedge clk) disable iff (rst)
        hsync |-> hblank);

    p_phase_excl_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({active, right_border, hblank}));

    p_phase_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(state_q));

endmodule

// File: rtl/hst_strobes.sv
module hst_strobes
    import hst_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  step,
    input  slot_t slot_nxt,
    input  slot_t slot_q,
    input  logic  wide_q,
    input  logic  first_vblank,
    output logic  hint_stb,
    output logic  vint_stb
);

    profile_t prof;

    always_comb prof = mode_profile(wide_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            hint_stb <= 1'b0;
            vint_stb <= 1'b0;
        end else begin
            hint_stb <= step && (slot_nxt == prof.hint_at);
            vint_stb <= step && (slot_nxt == VINT_AT) && first_vblank;
        end
    end

    p_hint_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        hint_stb |=> !hint_stb);

    p_hint_slot_r11: assert property (@(posedge clk) disable iff (rst)
        hint_stb |-> (slot_q == 8'h85 || slot_q == 8'hA5));

    p_vint_slot_r12: assert property (@(posedge clk) disable iff (rst)
        vint_stb |-> (slot_q == VINT_AT));

endmodule

// File: rtl/hslot_timing_gen.sv
module hslot_timing_gen
    import hst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              slot_en,
    input  logic              wide_mode,
    input  logic              first_vblank,
    output logic [SLOT_W-1:0] slot,
    output logic              active,
    output logic              right_border,
    output logic              hblank,
    output logic              hsync,
    output logic              hint_stb,
    output logic              vint_stb
);

    slot_t slot_q;
    slot_t slot_nxt;
    logic  step;
    logic  wide_q;
    logic  hsync_w;

    hst_slot_counter u_counter (
        .clk       (clk),
        .rst       (rst),
        .slot_en   (slot_en),
        .wide_mode (wide_mode),
        .in_sync   (hsync_w),
        .slot_q    (slot_q),
        .slot_nxt  (slot_nxt),
        .step      (step),
        .wide_q    (wide_q)
    );

    hst_phase_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .step         (step),
        .slot_nxt     (slot_nxt),
        .wide_q       (wide_q),
        .active       (active),
        .right_border (right_border),
        .hblank       (hblank),
        .hsync        (hsync_w)
    );

    hst_strobes u_strobes (
        .clk          (clk),
        .rst          (rst),
        .step         (step),
        .slot_nxt     (slot_nxt),
        .slot_q       (slot_q),
        .wide_q       (wide_q),
        .first_vblank (first_vblank),
        .hint_stb     (hint_stb),
        .vint_stb     (vint_stb)
    );

    assign slot  = slot_q;
    assign hsync = hsync_w;

    p_active_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (slot_q == 8'h00) |-> active);

endmodule

// File: tb/hslot_timing_gen_tb_top.sv
module hslot_timing_gen_tb_top;

    typedef struct packed {
        logic [7:0] slot;
        logic act;
        logic rb;
        logic hb;
        logic hs;
        logic hint;
        logic vint;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic slot_en = 1'b0;
    logic wide_mode = 1'b0;
    logic first_vblank = 1'b0;
    logic [7:0] slot;
    logic active, right_border, hblank, hsync, hint_stb, vint_stb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t q[$];

    int m_pos = 0;
    bit m_wide = 1'b0;
    bit m_half = 1'b0;
    bit m_hint = 1'b0;
    bit m_vint = 1'b0;

    always #5 clk = ~clk;

    hslot_timing_gen dut_i (
        .clk          (clk),
        .rst          (rst),
        .slot_en      (slot_en),
        .wide_mode    (wide_mode),
        .first_vblank (first_vblank),
        .slot         (slot),
        .active       (active),
        .right_border (right_border),
        .hblank       (hblank),
        .hsync        (hsync),
        .hint_stb     (hint_stb),
        .vint_stb     (vint_stb)
    );

    function automatic int line_len(bit w);
        return w ? 210 : 171;
    endfunction

    function automatic logic [7:0] pos_to_slot(bit w, int p);
        if (w) return (p < 183) ? 8'(p) : 8'(8'hE5 + (p - 183));
        return (p < 148) ? 8'(p) : 8'(8'hE9 + (p - 148));
    endfunction

    function automatic bit in_rng(int p, int lo, int hi);
        return (p >= lo) && (p <= hi);
    endfunction

    function automatic bit pos_hs(bit w, int p);
        return w ? in_rng(p, 173, 188) : in_rng(p, 140, 152);
    endfunction

    function automatic exp_t model_out();
        exp_t e;
        e.slot = pos_to_slot(m_wide, m_pos);
        e.act  = m_wide ? (m_pos < 160) : (m_pos < 128);
        e.rb   = m_wide ? in_rng(m_pos, 160, 167) : in_rng(m_pos, 128, 135);
        e.hb   = m_wide ? in_rng(m_pos, 168, 204) : in_rng(m_pos, 136, 165);
        e.hs   = pos_hs(m_wide, m_pos);
        e.hint = m_hint;
        e.vint = m_vint;
        return e;
    endfunction

    task automatic drive(input bit r, input bit en, input bit mode, input bit fvb);
        @(negedge clk);
        rst = r;
        slot_en = en;
        wide_mode = mode;
        first_vblank = fvb;
        m_hint = 1'b0;
        m_vint = 1'b0;
        if (r) begin
            m_pos = 0;
            m_half = 1'b0;
            m_wide = mode;
        end else if (en) begin
            if (m_wide && pos_hs(m_wide, m_pos) && !m_half) begin
                m_half = 1'b1;
            end else begin
                m_half = 1'b0;
                m_pos = m_pos + 1;
                if (m_pos == line_len(m_wide)) begin
                    m_pos = 0;
                    m_wide = mode;
                end
                m_hint = (m_pos == (m_wide ? 165 : 133));
                m_vint = (m_pos == 1) && fvb;
            end
        end
        q.push_back(model_out());
    endtask

    task automatic cmp(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                cmp("R1/R2/R3/R4/R5/R6 slot", slot, e.slot);
                cmp("R7 active", active, e.act);
                cmp("R8 right_border", right_border, e.rb);
                cmp("R9 hblank", hblank, e.hb);
                cmp("R10 hsync", hsync, e.hs);
                cmp("R11 hint_stb", hint_stb, e.hint);
                cmp("R12 vint_stb", vint_stb, e.vint);
            end
        end
    end

    initial begin
        // R1: reset state, narrow mode
        for (int i = 0; i < 3; i++) drive(1, 0, 0, 0);
        // R3 R7..R12: narrow lines at full rate, first_vblank high on line 2
        for (int i = 0; i < 400; i++) drive(0, 1, 0, (i >= 160 && i < 340));
        // R2: sparse enables in narrow mode, vblank pulsed off slot 0x01
        for (int i = 0; i < 400; i++) drive(0, (i % 3) != 0, 0, (i % 7) == 0);
        // R6: request wide mode mid-line; takes effect at wrap only
        for (int i = 0; i < 500; i++) drive(0, 1, 1, 1);
        // R4 R5: wide mode with sparse enables
        for (int i = 0; i < 500; i++) drive(0, (i % 4) != 1, 1, (i % 5) == 0);
        // R6: back to narrow mid-line
        for (int i = 0; i < 300; i++) drive(0, 1, 0, 0);
        // R1: reset mid-line selecting wide mode
        for (int i = 0; i < 200; i++) drive(0, 1, 1, 0);
        for (int i = 0; i < 2; i++) drive(1, 1, 1, 0);
        for (int i = 0; i < 260; i++) drive(0, 1, 1, 1);
        drive(0, 0, 1, 0);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule